// File: doc/BRIEF.md
# Delay-Locked Loop Bring-Up Sequencer

This block brings up the PHY delay-locked loop after the card clock has been
reprogrammed. A controller pulses a start input and presents two facts about the
new clock: whether its frequency actually changed, and the new rate in hertz.
The sequencer goes to work only when the rate changed and is strictly above 52 MHz.
In every other case it answers with a done pulse and leaves the loop configuration
word alone.

When it does run, it drives the loop configuration word through three staged
updates. The first disables the loop and its compensation paths. The second arms
compensation, search mode, the initial count and the internal phase. The third
enables the loop. A settle time separates each stage from the next. The block then
samples the loop status word at a fixed interval until the lock bit appears or a
total timeout runs out. It reports busy, a one-cycle done, and a locked or failed
outcome, and it keeps the configuration word and the last status sample on its
outputs for debug. All waiting is counted on a one-per-microsecond tick input, so
the real-time constants are parameters in microseconds.

Top module: `dll_lock_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done, locked and lock_fail are 0, dll_cfg equals the CFG_RESET parameter, and dbg_status is 0. A reset in the middle of a sequence returns the block to this state.
- R2: A start taken while idle, with rate_changed low or target_hz at most RATE_THRESH_HZ (52 000 000 by default; equal does not qualify), produces done in the cycle after the start edge, with locked and lock_fail at 0. Busy never rises and dll_cfg keeps its value.
- R3: A qualifying start updates dll_cfg at the start edge. Bit 21 (loop enable) and bits 18, 24, 25, 26 and 27 (compensation enables) are cleared, and all other bits are kept.
- R4: After SETTLE_US further ticks in the first stage, dll_cfg is ORed with bits 24 to 27, bit 18, bit 16 (search mode), 0xC00 (initial count) and 0x3 (internal phase). The update lands one cycle after the tick that completes the count.
- R5: After SETTLE_US further ticks in the second stage, bit 21 of dll_cfg is set in the same manner.
- R6: After SETTLE_US more ticks, dll_status is sampled each time POLL_US ticks have elapsed. On the first sample with bit 18 set, locked rises, done pulses and busy falls.
- R7: If none of the first TIMEOUT_US/POLL_US samples shows bit 18, lock_fail rises together with done at the last sample. Locked and lock_fail are never high together.
- R8: Done is high for exactly one cycle. Busy is high from the cycle after a qualifying start until the cycle in which done is high, where it is low. Locked and lock_fail hold their value until the next accepted start clears them.
- R9: A start pulse that arrives while busy is ignored: no done, no change to dll_cfg, and the running sequence completes on its own schedule.
- R10: dbg_status holds the dll_status word captured at the most recent sample.
- R11: Waiting advances only on cycles where us_tick is high. With us_tick low, the sequencer stays in its current stage indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start_req | input | 1 | Start pulse |
| rate_changed | input | 1 | The new clock rate differs from the previous one |
| target_hz | input | 32 | New clock rate in hertz |
| dll_status | input | 32 | Loop status word; bit 18 is lock |
| dll_cfg | output | 32 | Loop configuration word |
| dbg_status | output | 32 | Status word captured at the last sample |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Last sequence reached lock |
| lock_fail | output | 1 | Last sequence timed out without lock |

## Verification
The hardest cases to reach are the two sides of the timeout edge. In one, lock appears just in time for the final permitted sample. In the other, it appears one cycle too late and the block must report failure instead. The bench uses a lock model whose delay, counted from the cycle the enable bit appears, is a table entry. The delays are chosen so that lock lands exactly on a sample edge, one cycle after one, on the last sample, and one cycle past it. The timing parameters are shrunk so that every outcome is reached in a few dozen cycles. A run with the tick held low, with a stray start injected, shows that a stalled stage neither advances nor restarts.

// File: rtl/dll_seq_pkg.sv
// Package: shared state encoding and configuration-word bit masks for the
// delay-locked loop bring-up sequencer. Bit positions are fixed because the
// loop decodes the configuration word itself.
package dll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STG1  = 3'd1,
        ST_STG2  = 3'd2,
        ST_STG3  = 3'd3,
        ST_POLL  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_OFF  = 2'd1,
        UPD_ARM  = 2'd2,
        UPD_ON   = 2'd3
    } cfg_upd_t;

    localparam int unsigned LOCK_BIT    = 18;
    localparam logic [31:0] M_LOOP_EN   = 32'h0020_0000;  // bit 21
    localparam logic [31:0] M_COMP_EN   = 32'h0F04_0000;  // bits 18, 24..27
    localparam logic [31:0] M_SEARCH    = 32'h0001_0000;  // bit 16
    localparam logic [31:0] V_INIT_CNT  = 32'h0000_0C00;
    localparam logic [31:0] V_PHASE_INT = 32'h0000_0003;

endpackage

// File: rtl/dll_rate_gate.sv
// Module: decides whether a start request needs the bring-up sequence.
// Assumes target_hz is stable in the cycle start is presented.
module dll_rate_gate #(
    parameter logic [31:0] THRESH_HZ = 32'd52_000_000
) (
    input  logic        rate_changed,
    input  logic [31:0] target_hz,
    output logic        need_run
);
    // Purpose: run only on a real change to a rate strictly above threshold.
    always_comb begin
        need_run = rate_changed && (target_hz > THRESH_HZ);
    end
endmodule

// File: rtl/dll_tick_timer.sv
// Module: counts microsecond ticks up to a limit and then holds.
// Assumes the limit stays constant between restarts.
module dll_tick_timer #(
    parameter int unsigned W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Purpose: clear on restart, count ticks, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag that the programmed number of ticks has elapsed.
    always_comb begin
        expired = (cnt_q == limit);
    end
endmodule

// File: rtl/dll_cfg_stage.sv
// Module: computes the next configuration word for one staged update.
// Each update is a read-modify-write of the current word; UPD_NONE passes it on.
module dll_cfg_stage
    import dll_seq_pkg::*;
(
    input  logic [31:0] cur_cfg,
    input  cfg_upd_t    upd,
    output logic [31:0] nxt_cfg
);
    // Purpose: apply the masks for the selected stage.
    always_comb begin
        unique case (upd)
            UPD_OFF: nxt_cfg = cur_cfg & ~(M_LOOP_EN | M_COMP_EN);
            UPD_ARM: nxt_cfg = cur_cfg | M_COMP_EN | M_SEARCH | V_INIT_CNT | V_PHASE_INT;
            UPD_ON:  nxt_cfg = cur_cfg | M_LOOP_EN;
            default: nxt_cfg = cur_cfg;
        endcase
    end
endmodule

// File: rtl/dll_lock_seq.sv
// Module: delay-locked loop bring-up sequencer (top).
// Runs three staged configuration updates, SETTLE_US ticks apart, then samples
// the lock bit every POLL_US ticks for up to TIMEOUT_US ticks. Assumes us_tick
// is a single-cycle pulse and POLL_US divides TIMEOUT_US with a result of 1 or more.
module dll_lock_seq
    import dll_seq_pkg::*;
#(
    parameter int unsigned SETTLE_US      = 1000,
    parameter int unsigned POLL_US        = 2000,
    parameter int unsigned TIMEOUT_US     = 1_000_000,
    parameter logic [31:0] RATE_THRESH_HZ = 32'd52_000_000,
    parameter logic [31:0] CFG_RESET      = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        us_tick,
    input  logic        start_req,
    input  logic        rate_changed,
    input  logic [31:0] target_hz,
    input  logic [31:0] dll_status,
    output logic [31:0] dll_cfg,
    output logic [31:0] dbg_status,
    output logic        busy,
    output logic        done,
    output logic        locked,
    output logic        lock_fail
);
    localparam int unsigned WAIT_MAX0 = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
    localparam int unsigned WAIT_MAX  = (TIMEOUT_US > WAIT_MAX0) ? TIMEOUT_US : WAIT_MAX0;
    localparam int unsigned TW        = $clog2(WAIT_MAX + 1);
    localparam int unsigned MAX_POLLS = TIMEOUT_US / POLL_US;
    localparam int unsigned PW        = $clog2(MAX_POLLS + 1);

    seq_state_t    state_q;
    cfg_upd_t      upd;
    logic          need_run;
    logic          accept;
    logic          tmr_restart;
    logic          tmr_expired;
    logic [TW-1:0] tmr_limit;
    logic [PW-1:0] poll_cnt_q;
    logic [31:0]   cfg_q;
    logic [31:0]   cfg_nxt;
    logic [31:0]   stat_q;
    logic          done_q;
    logic          locked_q;
    logic          fail_q;

    dll_rate_gate #(.THRESH_HZ(RATE_THRESH_HZ)) u_gate (
        .rate_changed (rate_changed),
        .target_hz    (target_hz),
        .need_run     (need_run)
    );

    dll_tick_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (us_tick),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    dll_cfg_stage u_stage (
        .cur_cfg (cfg_q),
        .upd     (upd),
        .nxt_cfg (cfg_nxt)
    );

    // Purpose: select the stage update, timer restart and timer limit for this cycle.
    always_comb begin
        accept      = start_req && (state_q == ST_IDLE);
        upd         = UPD_NONE;
        tmr_restart = 1'b0;
        tmr_limit   = (state_q == ST_POLL) ? TW'(POLL_US) : TW'(SETTLE_US);
        unique case (state_q)
            ST_IDLE: if (accept && need_run) begin
                upd         = UPD_OFF;
                tmr_restart = 1'b1;
            end
            ST_STG1: if (tmr_expired) begin
                upd         = UPD_ARM;
                tmr_restart = 1'b1;
            end
            ST_STG2: if (tmr_expired) begin
                upd         = UPD_ON;
                tmr_restart = 1'b1;
            end
            ST_STG3: tmr_restart = tmr_expired;
            ST_POLL: tmr_restart = tmr_expired;
            default: ;
        endcase
    end

    // Purpose: sequence state, configuration word, sampling and outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cfg_q      <= CFG_RESET;
            stat_q     <= '0;
            poll_cnt_q <= '0;
            done_q     <= 1'b0;
            locked_q   <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (upd != UPD_NONE) begin
                cfg_q <= cfg_nxt;
            end
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    locked_q <= 1'b0;
                    fail_q   <= 1'b0;
                    if (need_run) begin
                        state_q <= ST_STG1;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
                ST_STG1: if (tmr_expired) state_q <= ST_STG2;
                ST_STG2: if (tmr_expired) state_q <= ST_STG3;
                ST_STG3: if (tmr_expired) begin
                    state_q    <= ST_POLL;
                    poll_cnt_q <= '0;
                end
                ST_POLL: if (tmr_expired) begin
                    stat_q     <= dll_status;
                    poll_cnt_q <= poll_cnt_q + 1'b1;
                    if (dll_status[LOCK_BIT]) begin
                        locked_q <= 1'b1;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else if (poll_cnt_q == PW'(MAX_POLLS - 1)) begin
                        fail_q  <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the outputs from registered state.
    always_comb begin
        dll_cfg    = cfg_q;
        dbg_status = stat_q;
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        locked     = locked_q;
        lock_fail  = fail_q;
    end
endmodule

// File: rtl/dll_lock_seq_chk.sv
// Module: assertion checker for the bring-up sequencer, bound to the top.
// Observes ports only.
module dll_lock_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        locked,
    input logic        lock_fail,
    input logic [31:0] dll_cfg
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R7
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && lock_fail));
    // R5
    locked_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> dll_cfg[21]);
    // R3
    stage_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((dll_cfg & 32'h0F24_0000) == 32'h0));
    // R2
    skip_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> $stable(dll_cfg));
endmodule

bind dll_lock_seq dll_lock_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .locked    (locked),
    .lock_fail (lock_fail),
    .dll_cfg   (dll_cfg)
);

// File: tb/dll_lock_seq_tb.sv
`timescale 1ns/1ps
module dll_lock_seq_tb;
    localparam logic [31:0] CFG0   = 32'hA020_00F0;
    localparam logic [31:0] ST_LK  = 32'h0004_5A5A;
    localparam logic [31:0] ST_NLK = 32'h0000_5A5A;

    typedef struct packed {
        logic        rc;
        logic [31:0] hz;
        logic [15:0] ld;
        logic [7:0]  cnt;
        logic        lk;
        logic        fl;
    } vec_t;

    // Timing with SETTLE 8, POLL 4, TIMEOUT 40: samples at edges 32,37..77 after start.
    localparam vec_t VECS [9] = '{
        '{1'b1, 32'd100_000_000, 16'd5,   8'd33, 1'b1, 1'b0},
        '{1'b1, 32'd100_000_000, 16'd13,  8'd33, 1'b1, 1'b0},
        '{1'b1, 32'd100_000_000, 16'd14,  8'd38, 1'b1, 1'b0},
        '{1'b1, 32'd52_000_001,  16'd15,  8'd38, 1'b1, 1'b0},
        '{1'b1, 32'd52_000_000,  16'd5,   8'd1,  1'b0, 1'b0},
        '{1'b0, 32'd200_000_000, 16'd5,   8'd1,  1'b0, 1'b0},
        '{1'b1, 32'd100_000_000, 16'd58,  8'd78, 1'b1, 1'b0},
        '{1'b1, 32'd100_000_000, 16'd59,  8'd78, 1'b0, 1'b1},
        '{1'b1, 32'd26_000_000,  16'd5,   8'd1,  1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b1;
    logic        start_req = 1'b0;
    logic        rate_changed = 1'b0;
    logic [31:0] target_hz = '0;
    logic [31:0] dll_status;
    logic [31:0] dll_cfg;
    logic [31:0] dbg_status;
    logic        busy, done, locked, lock_fail;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int lk_cnt = 0;
    int lock_delay = 5;

    always #2 clk = ~clk;

    dll_lock_seq #(
        .SETTLE_US(8), .POLL_US(4), .TIMEOUT_US(40), .CFG_RESET(CFG0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_req(start_req),
        .rate_changed(rate_changed), .target_hz(target_hz), .dll_status(dll_status),
        .dll_cfg(dll_cfg), .dbg_status(dbg_status), .busy(busy), .done(done),
        .locked(locked), .lock_fail(lock_fail)
    );

    // Loop model: locks lock_delay cycles after the enable bit appears.
    always @(posedge clk) begin
        if (!rst_n || !dll_cfg[21]) lk_cnt <= 0;
        else if (lk_cnt < 100000) lk_cnt <= lk_cnt + 1;
    end
    assign dll_status = (lk_cnt >= lock_delay) ? ST_LK : ST_NLK;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary();
            $finish;
        end
    end

    // Waits for done; returns the number of edges from the start edge to the done edge.
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 500) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        logic [31:0] prev_cfg;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 locked", {31'b0, locked}, 32'd0);
        chk("R1 fail", {31'b0, lock_fail}, 32'd0);
        chk("R1 cfg", dll_cfg, CFG0);
        chk("R1 dbg", dbg_status, 32'd0);
        rst_n = 1'b1;

        // Directed: staged updates, stalled tick, stray start while busy.
        @(negedge clk);
        rate_changed = 1'b1; target_hz = 32'd100_000_000; lock_delay = 5;
        us_tick = 1'b0; start_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        chk("R3 stage1 cfg", dll_cfg, 32'hA000_00F0);
        chk("R8 busy after start", {31'b0, busy}, 32'd1);
        repeat (4) @(negedge clk);
        rate_changed = 1'b0; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0; rate_changed = 1'b1;
        chk("R9 stray start no done", {31'b0, done}, 32'd0);
        chk("R9 stray start cfg", dll_cfg, 32'hA000_00F0);
        repeat (20) @(negedge clk);
        chk("R11 stalled tick cfg", dll_cfg, 32'hA000_00F0);
        chk("R11 stalled tick busy", {31'b0, busy}, 32'd1);
        us_tick = 1'b1;
        repeat (8) @(negedge clk);
        chk("R4 not early", dll_cfg, 32'hA000_00F0);
        @(negedge clk);
        chk("R4 stage2 cfg", dll_cfg, 32'hAF05_0CF3);
        repeat (8) @(negedge clk);
        chk("R5 not early", dll_cfg, 32'hAF05_0CF3);
        @(negedge clk);
        chk("R5 stage3 cfg", dll_cfg, 32'hAF25_0CF3);
        wait_done(n);
        chk("R6 locked", {31'b0, locked}, 32'd1);
        chk("R10 dbg on lock", dbg_status, ST_LK);
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done}, 32'd0);
        chk("R8 locked held", {31'b0, locked}, 32'd1);

        // Directed: reset in the middle of a sequence.
        start_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 midrun busy", {31'b0, busy}, 32'd0);
        chk("R1 midrun cfg", dll_cfg, CFG0);
        chk("R1 midrun locked", {31'b0, locked}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: thresholds, lock timing edges, timeout, skip after fail.
        for (int i = 0; i < 9; i++) begin
            prev_cfg = dll_cfg;
            rate_changed = VECS[i].rc;
            target_hz = VECS[i].hz;
            lock_delay = int'(VECS[i].ld);
            start_req = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_req = 1'b0;
            if (VECS[i].cnt == 8'd1) begin
                chk("R2 skip busy", {31'b0, busy}, 32'd0);
                chk("R2 skip cfg", dll_cfg, prev_cfg);
            end
            wait_done(n);
            chk(VECS[i].fl ? "R7 done cycle" : "R6 done cycle", n, 32'(VECS[i].cnt));
            chk("R6 locked", {31'b0, locked}, {31'b0, VECS[i].lk});
            chk("R7 lock_fail", {31'b0, lock_fail}, {31'b0, VECS[i].fl});
            if (VECS[i].cnt != 8'd1)
                chk("R10 dbg", dbg_status, VECS[i].lk ? ST_LK : ST_NLK);
            @(negedge clk);
            chk("R8 done low", {31'b0, done}, 32'd0);
            chk("R8 outcome held", {30'b0, locked, lock_fail}, {30'b0, VECS[i].lk, VECS[i].fl});
        end

        summary();
        $finish;
    end
endmodule